// File: doc/BRIEF.md
# Shared-Medium Transmit Deferral and Collision Backoff Controller

This block sits beside a frame serializer on a half-duplex 10 Mb/s shared medium and decides the moment a queued frame may go out. It watches carrier sense and counts idle bit times. A start pulse is issued only when a frame is waiting, the medium has been quiet for the full interframe gap, and no backoff wait is still running. The serializer and the CRC logic sit outside the block. The serializer reports either the end of a clean frame or nothing, while the medium reports collisions.

When a collision hits a frame in flight, the block stops the frame and drives a 32-bit jam word onto a one-bit jam output. It then pulses a retry request so that the buffer manager reloads the frame. After that it waits a random number of slot times. The number comes from an internal free-running LFSR and follows truncated binary exponential backoff. A four-bit attempt counter tracks consecutive collisions. Sticky status flags record that a collision occurred and that sixteen collisions in a row occurred, and the second flag can raise an interrupt.

Top module: `csma_backoff_ctl`

## Requirements
- R1: `tx_start` is a one-cycle pulse. It is issued only from the idle state, with `tx_pending` high and `carrier_sense` low, after at least IFG_BITS (default 96) `bit_tick` pulses have been seen while the medium was quiet and the block was not transmitting or jamming.
- R2: A `collision` seen while a frame is in flight moves the block into jamming. `jam_active` stays high for exactly JAM_BITS (default 32) `bit_tick` pulses. `jam_data` carries the jam word 0x55555555 least significant bit first and advances one bit per tick. `jam_data` is 0 whenever `jam_active` is low.
- R3: On the clock that follows the final jam tick, `jam_active` falls, `retry_req` pulses high for one cycle, and the backoff wait begins.
- R4: The backoff length in slots equals the low K bits of a 16-bit LFSR. The LFSR is seeded with 0xACE1 at reset and shifts left once per clock, with feedback equal to the XOR of bits 15, 13, 12 and 10. It is sampled on the edge where the jam ends. K is the attempt counter value after the collision, capped at BACKOFF_LIMIT (default 10). Each slot lasts SLOT_BITS `bit_tick` pulses.
- R5: Once the backoff wait is over, the block returns to idle, and the interframe gap rule of R1 still applies before the next `tx_start`.
- R6: `attempt_cnt` increments modulo 16 on every in-flight collision. It is cleared by a successful frame end (`tx_done` in flight without `collision`) and by `clr_cmd`.
- R7: `coll_status` is set by every in-flight collision and cleared by `clr_cmd`.
- R8: A collision that arrives while `attempt_cnt` is 15 (the sixteenth in a row) sets `excess_status` and wraps the counter to 0. `irq` equals `excess_status` AND `irq_enable`. `clr_cmd` clears `excess_status`.
- R9: A collision in the same cycle as `tx_done` counts as a collision. A collision in the same cycle as `clr_cmd` takes priority over the clear.
- R10: While `rst_n` is low, all outputs are 0.
- R11: `collision` and `tx_done` have no effect when no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per medium bit time |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected on the medium |
| tx_pending | input | 1 | A frame is queued for transmission |
| tx_done | input | 1 | Serializer finished the frame cleanly |
| clr_cmd | input | 1 | Clear attempt counter and status flags |
| irq_enable | input | 1 | Enables the excessive-collision interrupt |
| tx_start | output | 1 | Start-transmit grant pulse |
| jam_active | output | 1 | Jam word is being sent |
| jam_data | output | 1 | Serial jam bit |
| retry_req | output | 1 | Frame reload request pulse |
| attempt_cnt | output | ATT_W | Consecutive collision count |
| coll_status | output | 1 | Sticky collision flag |
| excess_status | output | 1 | Sticky sixteen-collision flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs one frame through sixteen back-to-back collisions so that the backoff exponent reaches its cap. The counter must wrap to zero at the same edge that sets the excess flag. A design with an off-by-one compare, or one that saturates instead of wrapping, would flag the wrong attempt or stall at 15. Carrier sense is raised in the middle of a backoff. A design that treats an expired backoff alone as enough to transmit would start before the gap has been rebuilt. The bench also drives collision together with a clean frame end, and collision together with a clear, and checks that the collision wins in both cases. It pulses collision and frame end while the block is idle and checks that neither reaches the counter or the flags. Every cycle the jam bit stream and the backoff length are compared against an independent LFSR model. A wrong bit order, a wrong exponent cap or an off-by-one slot count therefore shows up as a timing mismatch.

// File: rtl/csma_pkg.sv
package csma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_TX      = 2'd1,
      ST_JAM     = 2'd2,
      ST_BACKOFF = 2'd3
   } csma_state_e;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
   parameter int          W    = 16,
   parameter logic [W-1:0] TAPS = 16'hB400,
   parameter logic [W-1:0] SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] q
);
   logic fb;
   assign fb = ^(q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= SEED;
      else        q <= {q[W-2:0], fb};
   end
endmodule

// File: rtl/csma_defer_timer.sv
module csma_defer_timer #(
   parameter int IFG_BITS = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic busy,
   output logic idle_ok
);
   generate
      if (IFG_BITS == 0) begin : g_nogap
         assign idle_ok = ~busy;
      end else begin : g_gap
         localparam int CW = $clog2(IFG_BITS + 1);
         localparam logic [CW-1:0] GAP = CW'(IFG_BITS);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt_q <= '0;
            else if (busy)                   cnt_q <= '0;
            else if (bit_tick && cnt_q != GAP) cnt_q <= cnt_q + 1'b1;
         end
         assign idle_ok = (cnt_q == GAP);
      end
   endgenerate
endmodule

// File: rtl/csma_jam_gen.sv
module csma_jam_gen #(
   parameter int                 JAM_BITS = 32,
   parameter logic [JAM_BITS-1:0] PATTERN = 32'h5555_5555
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic bit_tick,
   output logic jam_bit,
   output logic last
);
   localparam int IW = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(JAM_BITS - 1);
   logic [IW-1:0] idx_q;

   assign last    = active && bit_tick && (idx_q == LAST_IDX);
   assign jam_bit = active & PATTERN[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx_q <= '0;
      else if (!active)  idx_q <= '0;
      else if (bit_tick) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
   end
endmodule

// File: rtl/csma_backoff_timer.sv
module csma_backoff_timer #(
   parameter int SLOT_BITS = 512,
   parameter int CNT_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_slots,
   output logic             expired
);
   localparam int SW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
   localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_BITS - 1);
   logic [CNT_W-1:0] slots_q;
   logic [SW-1:0]    bitc_q;

   assign expired = (slots_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slots_q <= '0;
         bitc_q  <= '0;
      end else if (load) begin
         slots_q <= load_slots;
         bitc_q  <= '0;
      end else if (!expired && bit_tick) begin
         if (bitc_q == SLOT_LAST) begin
            bitc_q  <= '0;
            slots_q <= slots_q - 1'b1;
         end else begin
            bitc_q <= bitc_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/csma_backoff_ctl.sv
module csma_backoff_ctl
   import csma_pkg::*;
#(
   parameter int          IFG_BITS      = 96,
   parameter int          SLOT_BITS     = 512,
   parameter int          JAM_BITS      = 32,
   parameter logic [31:0] JAM_PATTERN   = 32'h5555_5555,
   parameter int          BACKOFF_LIMIT = 10,
   parameter int          ATT_W         = 4,
   parameter int          LFSR_W        = 16,
   parameter logic [15:0] LFSR_TAPS     = 16'hB400,
   parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             carrier_sense,
   input  logic             collision,
   input  logic             tx_pending,
   input  logic             tx_done,
   input  logic             clr_cmd,
   input  logic             irq_enable,
   output logic             tx_start,
   output logic             jam_active,
   output logic             jam_data,
   output logic             retry_req,
   output logic [ATT_W-1:0] attempt_cnt,
   output logic             coll_status,
   output logic             excess_status,
   output logic             irq
);
   localparam int K_W = $clog2(BACKOFF_LIMIT + 1);
   localparam logic [ATT_W-1:0] ATT_LAST = '1;

   initial begin : elab_checks
      if (LFSR_W < BACKOFF_LIMIT) $error("LFSR_W must cover BACKOFF_LIMIT bits");
      if (JAM_BITS < 1 || JAM_BITS > 32) $error("JAM_BITS out of range");
      if (SLOT_BITS < 1) $error("SLOT_BITS must be positive");
      if (ATT_W < 1) $error("ATT_W must be positive");
   end

   csma_state_e state_q, state_d;
   logic [LFSR_W-1:0]        lfsr_q;
   logic                     idle_ok, jam_last, bo_expired, bo_load, start_go;
   logic                     coll_evt, succ_evt, busy;
   logic [K_W-1:0]           k_exp;
   logic [BACKOFF_LIMIT-1:0] draw;

   csma_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0]), .SEED(LFSR_SEED[LFSR_W-1:0])) u_lfsr (
      .clk(clk), .rst_n(rst_n), .q(lfsr_q));

   assign busy = carrier_sense | (state_q == ST_TX) | (state_q == ST_JAM);

   csma_defer_timer #(.IFG_BITS(IFG_BITS)) u_defer (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .busy(busy), .idle_ok(idle_ok));

   csma_jam_gen #(.JAM_BITS(JAM_BITS), .PATTERN(JAM_PATTERN[JAM_BITS-1:0])) u_jam (
      .clk(clk), .rst_n(rst_n), .active(state_q == ST_JAM), .bit_tick(bit_tick),
      .jam_bit(jam_data), .last(jam_last));

   assign k_exp = (attempt_cnt > ATT_W'(BACKOFF_LIMIT)) ? K_W'(BACKOFF_LIMIT) : K_W'(attempt_cnt);
   assign draw  = lfsr_q[BACKOFF_LIMIT-1:0] & ~({BACKOFF_LIMIT{1'b1}} << k_exp);

   csma_backoff_timer #(.SLOT_BITS(SLOT_BITS), .CNT_W(BACKOFF_LIMIT)) u_backoff (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(bo_load),
      .load_slots(draw), .expired(bo_expired));

   assign coll_evt = (state_q == ST_TX) && collision;
   assign succ_evt = (state_q == ST_TX) && !collision && tx_done;
   assign bo_load  = (state_q == ST_JAM) && jam_last;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (tx_pending && idle_ok && !carrier_sense) state_d = ST_TX;
         ST_TX:      if (collision) state_d = ST_JAM;
                     else if (tx_done) state_d = ST_IDLE;
         ST_JAM:     if (jam_last) state_d = ST_BACKOFF;
         ST_BACKOFF: if (bo_expired) state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   assign start_go   = (state_q == ST_IDLE) && (state_d == ST_TX);
   assign jam_active = (state_q == ST_JAM);
   assign irq        = excess_status & irq_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         tx_start      <= 1'b0;
         retry_req     <= 1'b0;
         attempt_cnt   <= '0;
         coll_status   <= 1'b0;
         excess_status <= 1'b0;
      end else begin
         state_q   <= state_d;
         tx_start  <= start_go;
         retry_req <= bo_load;
         if (coll_evt)                 attempt_cnt <= attempt_cnt + 1'b1;
         else if (succ_evt || clr_cmd) attempt_cnt <= '0;
         if (coll_evt)     coll_status <= 1'b1;
         else if (clr_cmd) coll_status <= 1'b0;
         if (coll_evt && attempt_cnt == ATT_LAST) excess_status <= 1'b1;
         else if (clr_cmd)                        excess_status <= 1'b0;
      end
   end
endmodule

// File: rtl/csma_backoff_ctl_chk.sv
module csma_backoff_ctl_chk #(
   parameter int ATT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             carrier_sense,
   input logic             collision,
   input logic             tx_pending,
   input logic             tx_start,
   input logic             jam_active,
   input logic             jam_data,
   input logic             retry_req,
   input logic [ATT_W-1:0] attempt_cnt,
   input logic             coll_status,
   input logic             excess_status,
   input logic             irq
);
   p_start_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> ($past(tx_pending) && !$past(carrier_sense)));
   p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);
   p_jam_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jam_active) |-> $past(collision));
   p_jam_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !jam_active |-> !jam_data);
   p_retry_after_jam_r3: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> ($past(jam_active) && !jam_active));
   p_retry_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |=> !retry_req);
   p_att_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (attempt_cnt != $past(attempt_cnt)) |->
         (attempt_cnt == $past(attempt_cnt) + 1'b1 || attempt_cnt == '0));
   p_att_needs_coll_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (attempt_cnt != '0) |-> coll_status);
   p_excess_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(excess_status) |-> (coll_status && attempt_cnt == '0));
   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> excess_status);
endmodule

bind csma_backoff_ctl csma_backoff_ctl_chk #(.ATT_W(ATT_W)) u_chk (.*);

// File: tb/csma_backoff_ctl_bench.sv
module csma_backoff_ctl_bench;
   localparam int IFG  = 96;
   localparam int SLOT = 4;
   localparam int JAMN = 32;
   localparam int LIM  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0, carrier_sense = 1'b0, collision = 1'b0, tx_pending = 1'b0;
   logic tx_done = 1'b0, clr_cmd = 1'b0, irq_enable = 1'b0;
   logic tx_start, jam_active, jam_data, retry_req, coll_status, excess_status, irq;
   logic [3:0] attempt_cnt;

   always #4 clk = ~clk;

   csma_backoff_ctl #(.IFG_BITS(IFG), .SLOT_BITS(SLOT)) u_csma_backoff_ctl (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .carrier_sense(carrier_sense),
      .collision(collision), .tx_pending(tx_pending), .tx_done(tx_done), .clr_cmd(clr_cmd),
      .irq_enable(irq_enable), .tx_start(tx_start), .jam_active(jam_active),
      .jam_data(jam_data), .retry_req(retry_req), .attempt_cnt(attempt_cnt),
      .coll_status(coll_status), .excess_status(excess_status), .irq(irq));

   int checks = 0;
   int fails  = 0;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model: 0 idle, 1 in flight, 2 jamming, 3 backoff
   int m_st, m_idle, m_jidx, m_slots, m_bitc, m_att, m_coll, m_exc, m_start, m_retry;
   logic [15:0] m_lfsr;
   int n_st, n_idle, n_jidx, n_slots, n_bitc, n_att, n_coll, n_exc, n_start, n_retry, k;
   bit cev, sev, loaded;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_idle = 0; m_jidx = 0; m_slots = 0; m_bitc = 0;
         m_att = 0; m_coll = 0; m_exc = 0; m_start = 0; m_retry = 0;
         m_lfsr = 16'hACE1;
      end else begin
         n_st = m_st; n_jidx = m_jidx; n_slots = m_slots; n_bitc = m_bitc;
         n_start = 0; n_retry = 0; loaded = 0;
         cev = (m_st == 1) && collision;
         sev = (m_st == 1) && !collision && tx_done;
         if (carrier_sense || m_st == 1 || m_st == 2) n_idle = 0;
         else if (bit_tick && m_idle < IFG)          n_idle = m_idle + 1;
         else                                        n_idle = m_idle;
         case (m_st)
            0: if (tx_pending && m_idle == IFG && !carrier_sense) begin n_st = 1; n_start = 1; end
            1: if (collision) n_st = 2; else if (tx_done) n_st = 0;
            2: if (bit_tick) begin
                  if (m_jidx == JAMN - 1) begin
                     n_st = 3; n_retry = 1; loaded = 1;
                     k = (m_att > LIM) ? LIM : m_att;
                     n_slots = int'(m_lfsr) & ((1 << k) - 1);
                     n_bitc = 0;
                  end else n_jidx = m_jidx + 1;
               end
            default: if (m_slots == 0) n_st = 0;
         endcase
         if (m_st != 2 || n_st != 2) n_jidx = (m_st == 2 && n_st == 2) ? n_jidx : 0;
         if (!loaded && m_slots != 0 && bit_tick) begin
            if (m_bitc == SLOT - 1) begin n_bitc = 0; n_slots = m_slots - 1; end
            else n_bitc = m_bitc + 1;
         end
         n_att  = cev ? (m_att + 1) % 16 : ((sev || clr_cmd) ? 0 : m_att);
         n_coll = cev ? 1 : (clr_cmd ? 0 : m_coll);
         n_exc  = (cev && m_att == 15) ? 1 : (clr_cmd ? 0 : m_exc);
         m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
         m_st = n_st; m_idle = n_idle; m_jidx = n_jidx; m_slots = n_slots; m_bitc = n_bitc;
         m_att = n_att; m_coll = n_coll; m_exc = n_exc; m_start = n_start; m_retry = n_retry;
      end
   end

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 R5 tx_start", int'(tx_start), m_start);
         check("R2 jam_active", int'(jam_active), (m_st == 2) ? 1 : 0);
         check("R2 jam_data", int'(jam_data), (m_st == 2) ? ((32'h5555_5555 >> m_jidx) & 1) : 0);
         check("R3 R4 retry_req", int'(retry_req), m_retry);
         check("R6 R9 R11 attempt_cnt", int'(attempt_cnt), m_att);
         check("R7 coll_status", int'(coll_status), m_coll);
         check("R8 excess_status", int'(excess_status), m_exc);
         check("R8 irq", int'(irq), m_exc & int'(irq_enable));
      end
   end

   initial begin
      forever begin
         @(posedge clk); #1 bit_tick = ~bit_tick;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_start(input string tag);
      int i;
      for (i = 0; i < 30000; i++) begin
         @(negedge clk);
         if (tx_start) break;
      end
      if (i == 30000) check({tag, " start timeout"}, 0, 1);
      @(posedge clk); #1;
   endtask

   task automatic pulse_coll();
      collision = 1'b1; cycles(1); collision = 1'b0;
   endtask

   task automatic finish_bench();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      finish_bench();
   end

   initial begin
      cycles(3);
      @(negedge clk);
      // R10: reset values
      check("R10 tx_start", int'(tx_start), 0);
      check("R10 jam_active", int'(jam_active), 0);
      check("R10 retry_req", int'(retry_req), 0);
      check("R10 attempt_cnt", int'(attempt_cnt), 0);
      check("R10 status", int'(coll_status | excess_status | irq), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R1: carrier busy, then clean frame
      carrier_sense = 1'b1; tx_pending = 1'b1;
      cycles(50);
      check("R1 no start while busy", int'(tx_start), 0);
      carrier_sense = 1'b0;
      wait_start("R1");
      cycles(20);
      tx_done = 1'b1; tx_pending = 1'b0; cycles(1); tx_done = 1'b0;
      cycles(5);

      // R11: events while idle
      pulse_coll();
      tx_done = 1'b1; cycles(1); tx_done = 1'b0;
      cycles(2);
      check("R11 attempt_cnt idle", int'(attempt_cnt), 0);
      check("R11 coll_status idle", int'(coll_status), 0);

      // R2 R3 R4 R5: one collision, carrier during backoff
      tx_pending = 1'b1;
      wait_start("R2");
      cycles(10);
      pulse_coll();
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (retry_req) break;
      end
      @(posedge clk); #1 carrier_sense = 1'b1;
      cycles(30);
      carrier_sense = 1'b0;
      wait_start("R5");
      check("R6 attempt after one collision", int'(attempt_cnt), 1);
      check("R7 coll after one collision", int'(coll_status), 1);
      cycles(8);
      tx_done = 1'b1; cycles(1); tx_done = 1'b0;
      cycles(1);
      check("R6 success clears", int'(attempt_cnt), 0);
      clr_cmd = 1'b1; cycles(1); clr_cmd = 1'b0;
      cycles(1);
      check("R7 clear", int'(coll_status), 0);

      // R8: sixteen consecutive collisions
      irq_enable = 1'b1;
      for (int n = 1; n <= 16; n++) begin
         wait_start("R8");
         cycles(3);
         pulse_coll();
      end
      cycles(2);
      check("R8 excess set", int'(excess_status), 1);
      check("R8 irq raised", int'(irq), 1);
      check("R8 counter wrapped", int'(attempt_cnt), 0);
      irq_enable = 1'b0; cycles(1);
      check("R8 irq masked", int'(irq), 0);

      // R9: collision with tx_done
      wait_start("R9");
      cycles(2);
      collision = 1'b1; tx_done = 1'b1; cycles(1); collision = 1'b0; tx_done = 1'b0;
      cycles(1);
      check("R9 collision beats done", int'(attempt_cnt), 1);
      // R9: collision with clear
      wait_start("R9b");
      cycles(2);
      collision = 1'b1; clr_cmd = 1'b1; cycles(1); collision = 1'b0; clr_cmd = 1'b0;
      cycles(1);
      check("R9 collision beats clear", int'(attempt_cnt), 2);
      check("R9 coll kept", int'(coll_status), 1);
      check("R9 excess cleared", int'(excess_status), 0);
      wait_start("R9c");
      cycles(4);
      tx_done = 1'b1; tx_pending = 1'b0; cycles(1); tx_done = 1'b0;
      cycles(20);
      finish_bench();
   end
endmodule